// File: doc/BRIEF.md
# Transactional Probe Arbiter

This unit sits beside a core's first-level data cache and decides, one probe at a time, whether a coherence invalidation or downgrade is allowed to take effect or is refused. While a transaction runs, it keeps three flags for every cache line: read speculatively, written speculatively, and touched by a labeled (commutative) operation. A probe that lands on a flagged line is a conflict. The older transaction wins the conflict. Age is given by unique unsigned timestamps, and a lower value means older. A probe that carries no timestamp comes from non-speculative code and is never refused.

Two other events also end the transaction: the eviction of a flagged line, and a refusal of the core's own reduction request. After such a refusal the unit waits until the core reports that it has merged every value it collected, and only then aborts. On an abort the unit gives a one-cycle abort pulse and a mask of the speculatively written lines that the cache must invalidate. On a commit it drops every flag. Every response is registered, so outputs appear one clock after the stimulus.

Top module: `tx_probe_arbiter`

## Requirements
- R1: After reset, tx_active, abort, resp_honor and resp_nack are all 0 and inv_lines is 0.
- R2: A probe to a line with none of its three flags set, or any probe while no transaction is active, is answered with resp_honor=1 and resp_nack=0 in the next cycle, and causes no abort.
- R3: While a transaction is active, an access with acc_kind 0 (read), 1 (write) or 2 (labeled) flags line acc_idx. A later timestamped probe to that line with probe_ts lower than local_ts is honored, abort pulses in the next cycle, and tx_active falls.
- R4: A timestamped conflicting probe with local_ts strictly lower than probe_ts gets resp_nack=1 and resp_honor=0. The local transaction does not abort and stays active.
- R5: A probe with probe_ts_valid=0 is never refused. If it hits a flagged line, it is honored and the local transaction aborts.
- R6: A red_nack pulse during an active transaction does not abort it by itself. The abort pulse follows the next red_done pulse, one cycle later.
- R7: A tx_commit pulse ends the transaction without an abort and clears every flag, so a probe in a later transaction to a line flagged before the commit is honored without conflict.
- R8: An eviction (evict_valid) of a flagged line aborts the active transaction. An eviction of an unflagged line has no effect.
- R9: abort is high for exactly one cycle. In that cycle inv_lines holds the set of lines written in the aborted transaction (bit i for line i), and is 0 in every other cycle. All flags are cleared by the abort.
- R10: With equal timestamps the comparison is strict less-than, so the local side does not win: the probe is honored and the local transaction aborts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_ts | input | TSW | Timestamp of the running local transaction |
| tx_begin | input | 1 | Start a transaction (ignored while one is active) |
| tx_commit | input | 1 | Commit the active transaction |
| acc_valid | input | 1 | Speculative access by the local transaction |
| acc_idx | input | IW | Line index of the access |
| acc_kind | input | 2 | 0 read, 1 write, 2 labeled |
| probe_valid | input | 1 | Incoming invalidation or downgrade probe |
| probe_idx | input | IW | Line index hit by the probe |
| probe_ts_valid | input | 1 | Probe carries a requester timestamp |
| probe_ts | input | TSW | Requester timestamp |
| evict_valid | input | 1 | Line eviction from the L1 |
| evict_idx | input | IW | Evicted line index |
| red_nack | input | 1 | Own reduction request was refused |
| red_done | input | 1 | Own reduction merge has finished |
| tx_active | output | 1 | A transaction is running |
| resp_honor | output | 1 | Previous-cycle probe is honored |
| resp_nack | output | 1 | Previous-cycle probe is refused |
| abort | output | 1 | One-cycle abort pulse |
| inv_lines | output | NLINES | Written lines to invalidate, valid with abort |

## Verification
On every cycle the assertions check that a probe always gets exactly one answer, that untimed probes are never refused, that an abort lasts one cycle, needs a running transaction and ends it, and that a refused reduction cannot abort before its merge completes. The timestamp ordering, the equal-timestamp case, the contents of the invalidation mask, and the clearing of the flags on commit and abort depend on the order of stimulus. Only the bench scenarios can show these, by touching lines and probing them again later.

// File: rtl/tx_probe_arbiter.sv
module tx_probe_arbiter #(
  parameter int NLINES = 16,
  parameter int TSW = 16,
  localparam int IW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [TSW-1:0]    local_ts,
  input  logic              tx_begin,
  input  logic              tx_commit,
  input  logic              acc_valid,
  input  logic [IW-1:0]     acc_idx,
  input  logic [1:0]        acc_kind,
  input  logic              probe_valid,
  input  logic [IW-1:0]     probe_idx,
  input  logic              probe_ts_valid,
  input  logic [TSW-1:0]    probe_ts,
  input  logic              evict_valid,
  input  logic [IW-1:0]     evict_idx,
  input  logic              red_nack,
  input  logic              red_done,
  output logic              tx_active,
  output logic              resp_honor,
  output logic              resp_nack,
  output logic              abort,
  output logic [NLINES-1:0] inv_lines
);

  logic [NLINES-1:0] rd_q, wr_q, lb_q;
  logic nack_pend;

  wire [NLINES-1:0] spec = rd_q | wr_q | lb_q;
  wire probe_hit  = probe_valid & tx_active & spec[probe_idx];
  wire local_wins = probe_ts_valid & (local_ts < probe_ts);
  wire nack_now   = probe_hit & local_wins;
  wire evict_hit  = evict_valid & tx_active & spec[evict_idx];
  wire red_abort  = tx_active & red_done & (nack_pend | red_nack);
  wire abort_now  = (probe_hit & ~local_wins) | evict_hit | red_abort;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_q <= '0; wr_q <= '0; lb_q <= '0;
      nack_pend <= 1'b0; tx_active <= 1'b0;
      resp_honor <= 1'b0; resp_nack <= 1'b0;
      abort <= 1'b0; inv_lines <= '0;
    end else begin
      resp_honor <= probe_valid & ~nack_now;
      resp_nack  <= nack_now;
      abort      <= abort_now;
      inv_lines  <= abort_now ? wr_q : '0;
      if (abort_now || (tx_commit && tx_active)) begin
        rd_q <= '0; wr_q <= '0; lb_q <= '0;
        nack_pend <= 1'b0; tx_active <= 1'b0;
      end else if (tx_begin && !tx_active) begin
        rd_q <= '0; wr_q <= '0; lb_q <= '0;
        nack_pend <= 1'b0; tx_active <= 1'b1;
      end else if (tx_active) begin
        if (acc_valid) begin
          case (acc_kind)
            2'd0: rd_q[acc_idx] <= 1'b1;
            2'd1: wr_q[acc_idx] <= 1'b1;
            2'd2: lb_q[acc_idx] <= 1'b1;
            default: ;
          endcase
        end
        if (red_nack) nack_pend <= 1'b1;
      end
    end
  end

  assert_one_answer_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(resp_honor && resp_nack));
  assert_probe_answered_R2: assert property (@(posedge clk) disable iff (!rst_n)
    probe_valid |=> (resp_honor || resp_nack));
  assert_untimed_never_nacked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_valid && !probe_ts_valid) |=> !resp_nack);
  assert_abort_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> !abort);
  assert_abort_ends_tx_R3: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> (!tx_active && $past(tx_active)));
  assert_merge_before_abort_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && red_nack && !red_done && !probe_valid && !evict_valid) |=> !abort);

endmodule

// File: tb/tx_probe_arbiter_tb.sv
`timescale 1ns/1ps
module tx_probe_arbiter_tb;
  localparam int NL = 16;
  localparam int TW = 16;
  localparam int IW = $clog2(NL);

  logic clk = 0, rst_n = 0;
  logic [TW-1:0] local_ts = '0, probe_ts = '0;
  logic tx_begin = 0, tx_commit = 0, acc_valid = 0, probe_valid = 0, probe_ts_valid = 0;
  logic evict_valid = 0, red_nack = 0, red_done = 0;
  logic [IW-1:0] acc_idx = '0, probe_idx = '0, evict_idx = '0;
  logic [1:0] acc_kind = '0;
  logic tx_active, resp_honor, resp_nack, abort;
  logic [NL-1:0] inv_lines;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tx_probe_arbiter #(.NLINES(NL), .TSW(TW)) u_dut (
    .clk, .rst_n, .local_ts, .tx_begin, .tx_commit, .acc_valid, .acc_idx, .acc_kind,
    .probe_valid, .probe_idx, .probe_ts_valid, .probe_ts, .evict_valid, .evict_idx,
    .red_nack, .red_done, .tx_active, .resp_honor, .resp_nack, .abort, .inv_lines);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  task automatic begin_tx(logic [TW-1:0] ts);
    local_ts = ts; tx_begin = 1; @(negedge clk); tx_begin = 0;
  endtask

  task automatic touch(int idx, int kind);
    acc_valid = 1; acc_idx = IW'(idx); acc_kind = 2'(kind);
    @(negedge clk); acc_valid = 0;
  endtask

  task automatic probe(string tag, int idx, bit tv, logic [TW-1:0] ts,
                       bit eh, bit en, bit ea, logic [NL-1:0] einv);
    probe_valid = 1; probe_idx = IW'(idx); probe_ts_valid = tv; probe_ts = ts;
    @(negedge clk);
    probe_valid = 0; probe_ts_valid = 0;
    chk({tag, " honor"}, 32'(resp_honor), 32'(eh));
    chk({tag, " nack"}, 32'(resp_nack), 32'(en));
    chk({tag, " abort"}, 32'(abort), 32'(ea));
    chk({tag, " inv"}, 32'(inv_lines), 32'(einv));
  endtask

  task automatic t_reset();
    chk("R1 active", 32'(tx_active), 0);
    chk("R1 abort", 32'(abort), 0);
    chk("R1 resp", 32'({resp_honor, resp_nack}), 0);
    chk("R1 inv", 32'(inv_lines), 0);
  endtask

  task automatic t_untouched();
    probe("R2 no tx", 3, 1, 16'd5, 1, 0, 0, '0);
    begin_tx(16'd100); touch(2, 0);
    probe("R2 other line", 5, 1, 16'd50, 1, 0, 0, '0);
    chk("R2 still active", 32'(tx_active), 1);
  endtask

  task automatic t_younger();
    probe("R3 read hit", 2, 1, 16'd50, 1, 0, 1, '0);
    chk("R3 tx ended", 32'(tx_active), 0);
    idle();
    chk("R9 abort one cycle", 32'(abort), 0);
  endtask

  task automatic t_older_and_untimed();
    begin_tx(16'd100); touch(7, 1); touch(9, 2);
    probe("R4 labeled hit", 9, 1, 16'd200, 0, 1, 0, '0);
    probe("R4 write hit", 7, 1, 16'd300, 0, 1, 0, '0);
    chk("R4 still active", 32'(tx_active), 1);
    probe("R5 untimed", 7, 0, 16'd999, 1, 0, 1, NL'(1) << 7);
    idle();
    chk("R9 inv cleared", 32'(inv_lines), 0);
    begin_tx(16'd100);
    probe("R9 flags cleared", 9, 1, 16'd200, 1, 0, 0, '0);
    tx_commit = 1; idle(); tx_commit = 0;
  endtask

  task automatic t_equal();
    begin_tx(16'd100); touch(1, 0);
    probe("R10 equal ts", 1, 1, 16'd100, 1, 0, 1, '0);
  endtask

  task automatic t_commit();
    begin_tx(16'd40); touch(4, 1);
    tx_commit = 1; idle(); tx_commit = 0;
    chk("R7 commit ends", 32'(tx_active), 0);
    chk("R7 no abort", 32'(abort), 0);
    begin_tx(16'd40);
    probe("R7 flags gone", 4, 1, 16'd10, 1, 0, 0, '0);
    tx_commit = 1; idle(); tx_commit = 0;
  endtask

  task automatic t_evict();
    begin_tx(16'd60); touch(6, 0);
    evict_valid = 1; evict_idx = IW'(8); idle(); evict_valid = 0;
    chk("R8 clean evict", 32'(abort), 0);
    chk("R8 still active", 32'(tx_active), 1);
    evict_valid = 1; evict_idx = IW'(6); idle(); evict_valid = 0;
    chk("R8 spec evict aborts", 32'(abort), 1);
  endtask

  task automatic t_reduce();
    begin_tx(16'd70); touch(3, 2);
    red_nack = 1; idle(); red_nack = 0;
    chk("R6 no early abort", 32'(abort), 0);
    idle();
    chk("R6 waiting", 32'({abort, tx_active}), 1);
    red_done = 1; idle(); red_done = 0;
    chk("R6 abort after merge", 32'(abort), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle();
    t_reset();
    t_untouched();
    t_younger();
    t_older_and_untimed();
    t_equal();
    t_commit();
    t_evict();
    t_reduce();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule